// File: doc/BRIEF.md
# I2C Register Port with Transmit-FIFO Backpressure

This block is an I2C target that gives an external host access to an internal register file and to a transmit FIFO. It samples SCL and SDA on a fast system clock and finds START and STOP conditions from the synchronized levels. After a START it compares the first byte with its own 7-bit target address. On a write it takes a register pointer byte and then streams data bytes. Each data byte becomes a one-cycle register write strobe, or a FIFO push when the pointer selects the FIFO register. A read uses a repeated START with the direction bit set. The target then shifts out register bytes, most significant bit first, until the host answers a byte with a NACK.

The pointer advances after every register byte written or read. It stays fixed while it selects the FIFO register, so a burst keeps pushing into the same queue. When the FIFO reports full, a byte aimed at it is dropped and left unacknowledged. The host therefore sees backpressure on the bus itself. SDA is open-drain: the block only ever asserts a pull-low enable.

States: IDLE (bus released, waits for START), ADDR (receiving the address byte), SUB (receiving the pointer byte), WDATA (receiving data bytes), ACK_WAIT (byte complete, waits for SCL low), ACK_DRIVE (holds or releases SDA for the ninth clock), RDATA (shifting a read byte out), RACK_WAIT (releases SDA after the eighth read bit), RACK (samples the host acknowledge). Transitions: START in any state goes to ADDR, and STOP in any state goes to IDLE. ADDR goes to ACK_WAIT on a matching eighth bit and to IDLE on a mismatch. SUB and WDATA go to ACK_WAIT on the eighth bit. ACK_WAIT goes to ACK_DRIVE on SCL falling. ACK_DRIVE, on SCL falling, goes to SUB, WDATA or RDATA, as the acknowledged byte decided. RDATA goes to RACK_WAIT on the eighth bit, and RACK_WAIT goes to RACK on SCL falling. RACK, on SCL falling, goes to RDATA after a host ACK and to IDLE after a NACK.

Top module: `i2c_regport`

## Requirements
- R1: After reset, sda_oe, reg_wr, reg_rd and fifo_push are all low.
- R2: A byte after START whose upper seven bits equal TARGET_ADDR (default 7'h2A) is acknowledged by pulling SDA low during the ninth SCL high period; bit 0 of that byte selects write (0) or read (1).
- R3: An address byte that does not match is not acknowledged, and no strobe is issued for any byte that follows it until the next START.
- R4: In a write, the byte after the address loads the register pointer. Each following data byte gives one reg_wr pulse with reg_addr equal to the pointer and wr_data equal to the byte, and is acknowledged. The pointer then increments. At most one of reg_wr, reg_rd, fifo_push is high in any cycle.
- R5: While the pointer equals FIFO_REG (default 8'h0F), data bytes give fifo_push instead of reg_wr and the pointer does not change, so successive bytes are all pushed.
- R6: A data byte aimed at FIFO_REG while fifo_full is high is not acknowledged and causes no push; a later byte of the same burst is accepted once fifo_full is low.
- R7: After a repeated START and a matching address with the read bit set, the target shifts out reg_rdata for the current pointer, MSB first, pulses reg_rd once per byte and increments the pointer after each byte.
- R8: When the host NACKs a read byte, the target releases SDA and drives nothing further until the next START.
- R9: A START seen in the middle of a byte discards the partial byte and begins a new address byte.
- R10: sda_oe changes only while the synchronized SCL is low.
- R11: reg_wr and fifo_push are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe; reg_rdata is captured in the same cycle |
| reg_addr | output | 8 | Current register pointer |
| reg_rdata | input | 8 | Register read data for reg_addr |
| wr_data | output | 8 | Data byte for reg_wr or fifo_push |
| fifo_push | output | 1 | Transmit FIFO push strobe |
| fifo_full | input | 1 | Transmit FIFO full |

## Verification
The assertions take for granted that each SCL high and low phase lasts several system clocks longer than the synchronizer delay. Under that condition a registered SDA update triggered by SCL falling lands while SCL is still low. They also take for granted that the host never makes a START or STOP while the target is pulling SDA low, which a legal host cannot do. The stimulus holds each SCL phase for twenty system clocks. It changes SDA only a quarter period after SCL falls. It issues START and STOP only after the target has released the line, or after reading a byte the target drove high.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_RDATA,
        ST_RACK_WAIT,
        ST_RACK
    } tgt_state_e;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 3;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    // One extra stage beyond the synchronizer keeps the previous level.
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic            scl_prv;
    logic            sda_prv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl  = scl_p[STAGES-1];
    assign sda_lvl  = sda_p[STAGES-1];
    assign scl_prv  = scl_p[STAGES];
    assign sda_prv  = sda_p[STAGES];

    assign scl_rise = scl_lvl & ~scl_prv;
    assign scl_fall = ~scl_lvl & scl_prv;
    // SDA moving while SCL stays high marks a bus condition.
    assign start_c  = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
    assign stop_c   = scl_lvl & scl_prv & ~sda_prv & sda_lvl;

endmodule

// File: rtl/i2c_subaddr.sv
module i2c_subaddr #(
    parameter int           AW       = 8,
    parameter logic [AW-1:0] FIFO_REG = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] sub_q,
    output logic          is_fifo
);

    assign is_fifo = (sub_q == FIFO_REG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (load) begin
            sub_q <= load_val;
        end else if (step && !is_fifo) begin
            sub_q <= sub_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              fifo_full,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              sub_is_fifo,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              fifo_push,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sub_load,
    output logic [BYTE_W-1:0] sub_val,
    output logic              sub_step
);

    tgt_state_e            st, nxt;
    tgt_state_e            after_ack;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0]     rx_sh;
    logic [BYTE_W-1:0]     tx_sh;
    logic [BYTE_W-1:0]     byte_in;
    logic                  ack_go;
    logic                  host_ack;
    logic                  last_bit;
    logic                  addr_hit;
    logic                  bus_cond;
    logic                  load_rd;

    assign byte_in  = {rx_sh[BYTE_W-2:0], sda_lvl};
    assign last_bit = (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
    assign addr_hit = (byte_in[BYTE_W-1:1] == TARGET_ADDR);
    assign bus_cond = start_c | stop_c;

    // Fetch a read byte at the SCL fall that opens its first bit.
    assign load_rd  = scl_fall && !bus_cond &&
                      (((st == ST_ACK_DRIVE) && (after_ack == ST_RDATA)) ||
                       ((st == ST_RACK) && host_ack));
    assign reg_rd   = load_rd;
    assign sub_step = reg_wr | load_rd;
    assign sub_load = (st == ST_SUB) && scl_rise && last_bit && !bus_cond;
    assign sub_val  = byte_in;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (start_c) begin
            nxt = ST_ADDR;
        end else if (stop_c) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise && last_bit) begin
                        nxt = addr_hit ? ST_ACK_WAIT : ST_IDLE;
                    end
                end
                ST_SUB, ST_WDATA: begin
                    if (scl_rise && last_bit) begin
                        nxt = ST_ACK_WAIT;
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        nxt = ST_ACK_DRIVE;
                    end
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) begin
                        nxt = after_ack;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && last_bit) begin
                        nxt = ST_RACK_WAIT;
                    end
                end
                ST_RACK_WAIT: begin
                    if (scl_fall) begin
                        nxt = ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        nxt = host_ack ? ST_RDATA : ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            fifo_push <= 1'b0;
            wr_data   <= '0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ack_go    <= 1'b0;
            host_ack  <= 1'b0;
            after_ack <= ST_IDLE;
        end else begin
            reg_wr    <= 1'b0;
            fifo_push <= 1'b0;
            if (bus_cond) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= byte_in;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                if (st == ST_ADDR) begin
                                    ack_go    <= addr_hit;
                                    after_ack <= byte_in[0] ? ST_RDATA : ST_SUB;
                                end else if (st == ST_SUB) begin
                                    ack_go    <= 1'b1;
                                    after_ack <= ST_WDATA;
                                end else begin
                                    after_ack <= ST_WDATA;
                                    wr_data   <= byte_in;
                                    if (sub_is_fifo) begin
                                        ack_go    <= !fifo_full;
                                        fifo_push <= !fifo_full;
                                    end else begin
                                        ack_go <= 1'b1;
                                        reg_wr <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= ack_go;
                        end
                    end
                    ST_ACK_DRIVE, ST_RACK: begin
                        if ((st == ST_RACK) && scl_rise) begin
                            host_ack <= !sda_lvl;
                        end
                        if (load_rd) begin
                            tx_sh   <= reg_rdata;
                            sda_oe  <= !reg_rdata[BYTE_W-1];
                            bit_cnt <= '0;
                        end else if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= !tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // SDA only moves in the SCL low phase.
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // Write and push strobes last one cycle.
    p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_push_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);

    // Never push into a full FIFO.
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !$past(fifo_full));

    // A push only happens while the pointer selects the FIFO register.
    p_push_fifo_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> sub_is_fifo);

    // Strobes are mutually exclusive.
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_wr, reg_rd, fifo_push}) <= 1);

    // An idle target has released the line.
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0]        TARGET_ADDR = 7'h2A,
    parameter logic [BYTE_W-1:0] FIFO_REG    = 8'h0F,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] wr_data,
    output logic              fifo_push,
    input  logic              fifo_full
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic              sub_load, sub_step, sub_is_fifo;
    logic [BYTE_W-1:0] sub_val;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2c_subaddr #(
        .AW       (BYTE_W),
        .FIFO_REG (FIFO_REG)
    ) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sub_load),
        .load_val (sub_val),
        .step     (sub_step),
        .sub_q    (reg_addr),
        .is_fifo  (sub_is_fifo)
    );

    i2c_target_fsm #(
        .TARGET_ADDR (TARGET_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_c     (start_c),
        .stop_c      (stop_c),
        .fifo_full   (fifo_full),
        .reg_rdata   (reg_rdata),
        .sub_is_fifo (sub_is_fifo),
        .sda_oe      (sda_oe),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .fifo_push   (fifo_push),
        .wr_data     (wr_data),
        .sub_load    (sub_load),
        .sub_val     (sub_val),
        .sub_step    (sub_step)
    );

    // The pointer holds still across every FIFO push.
    p_fifo_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> (reg_addr == FIFO_REG));

endmodule

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;

    localparam int         TQ   = 10;
    localparam logic [6:0] TADR = 7'h2A;
    localparam logic [7:0] FREG = 8'h0F;
    localparam int         NVEC = 6;
    // {pointer, data}
    localparam logic [15:0] VEC [NVEC] = '{16'h005A, 16'h01C3, 16'h0200,
                                           16'h09FF, 16'h0E81, 16'h063C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, reg_wr, reg_rd, fifo_push;
    logic       fifo_full = 1'b0;
    logic [7:0] reg_addr, reg_rdata, wr_data;
    logic [7:0] mem [16];
    logic [7:0] last_push;
    int         wr_cnt = 0;
    int         push_cnt = 0;
    int         r10_bad = 0;
    int         r11_bad = 0;
    int         errors = 0;
    int         checks = 0;
    logic       prev_oe = 1'b0;
    logic       prev_wr = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr[3:0]];

    i2c_regport u_i2c_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .wr_data   (wr_data),
        .fifo_push (fifo_push),
        .fifo_full (fifo_full)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr[3:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (fifo_push) begin
            push_cnt  <= push_cnt + 1;
            last_push <= wr_data;
        end
        if (rst_n && (sda_oe != prev_oe) && scl_m) r10_bad <= r10_bad + 1;
        if (rst_n && reg_wr && prev_wr) r11_bad <= r11_bad + 1;
        prev_oe <= sda_oe;
        prev_wr <= reg_wr;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tq();
        repeat (TQ) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; tq(); scl_m = 1'b1; tq(); tq(); scl_m = 1'b0; tq();
    endtask

    task automatic start_c();
        sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); sda_m = 1'b0; tq(); scl_m = 1'b0; tq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); sda_m = 1'b1; tq(); tq();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); nack = sda_bus; tq(); scl_m = 1'b0; tq();
    endtask

    task automatic rbyte(input logic ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tq(); scl_m = 1'b1; tq(); d[i] = sda_bus; tq(); scl_m = 1'b0; tq();
        end
        bit_w(!ack);
    endtask

    task automatic write1(input logic [7:0] sub, input logic [7:0] d, output logic [2:0] nk);
        start_c();
        wbyte({TADR, 1'b0}, nk[2]);
        wbyte(sub, nk[1]);
        wbyte(d, nk[0]);
        stop_c();
    endtask

    task automatic read_setup(input logic [7:0] sub, output logic [2:0] nk);
        start_c();
        wbyte({TADR, 1'b0}, nk[2]);
        wbyte(sub, nk[1]);
        start_c();
        wbyte({TADR, 1'b1}, nk[0]);
    endtask

    initial begin
        logic [2:0] nk;
        logic       n;
        logic [7:0] d;
        int         w0, p0;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk({sda_oe, reg_wr, reg_rd, fifo_push} == 4'b0, "R1 reset outputs",
            {sda_oe, reg_wr, reg_rd, fifo_push}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Vector table: write one byte, read it back through a repeated START.
        for (int v = 0; v < NVEC; v++) begin
            write1(VEC[v][15:8], VEC[v][7:0], nk);
            chk(nk == 3'b000, "R2 R4 write acks", nk, 0);
            read_setup(VEC[v][15:8], nk);
            rbyte(1'b0, d);
            stop_c();
            chk(nk == 3'b000 && d == VEC[v][7:0], "R7 readback", d, VEC[v][7:0]);
        end

        // R3: mismatched address
        w0 = wr_cnt;
        start_c();
        wbyte({7'h30, 1'b0}, n);
        chk(n == 1'b1, "R3 mismatch not acked", n, 1);
        wbyte(8'h04, nk[1]);
        wbyte(8'h77, nk[0]);
        stop_c();
        chk(nk[1:0] == 2'b11 && wr_cnt == w0, "R3 no strobes after mismatch", wr_cnt, w0);

        // R4: burst write with pointer increment
        w0 = wr_cnt;
        start_c();
        wbyte({TADR, 1'b0}, nk[2]);
        wbyte(8'h03, nk[1]);
        wbyte(8'h11, nk[0]);
        wbyte(8'h22, n);
        wbyte(8'h33, n);
        stop_c();
        chk(wr_cnt == w0 + 3, "R4 burst write count", wr_cnt, w0 + 3);
        chk({mem[3], mem[4], mem[5]} == 24'h112233, "R4 pointer increment",
            {mem[3], mem[4], mem[5]}, 24'h112233);

        // R7: burst read from pointer 3
        read_setup(8'h03, nk);
        rbyte(1'b1, d);
        chk(d == 8'h11, "R7 read byte 0", d, 8'h11);
        rbyte(1'b1, d);
        chk(d == 8'h22, "R7 read byte 1 pointer increment", d, 8'h22);
        rbyte(1'b0, d);
        stop_c();
        chk(d == 8'h33, "R7 read byte 2", d, 8'h33);

        // R5: FIFO burst keeps the pointer
        w0 = wr_cnt;
        p0 = push_cnt;
        start_c();
        wbyte({TADR, 1'b0}, nk[2]);
        wbyte(FREG, nk[1]);
        wbyte(8'hA1, nk[0]);
        chk(nk == 3'b000, "R5 fifo byte acked", nk, 0);
        wbyte(8'hA2, n);
        wbyte(8'hA3, n);
        chk(push_cnt == p0 + 3 && wr_cnt == w0, "R5 three pushes no reg writes", push_cnt, p0 + 3);
        chk(last_push == 8'hA3 && reg_addr == FREG, "R5 last pushed byte", last_push, 8'hA3);

        // R6: full FIFO refuses, then accepts again
        fifo_full = 1'b1;
        p0 = push_cnt;
        wbyte(8'hB0, n);
        chk(n == 1'b1 && push_cnt == p0, "R6 full fifo nack", {n, push_cnt[7:0]}, {1'b1, p0[7:0]});
        fifo_full = 1'b0;
        wbyte(8'hB1, n);
        stop_c();
        chk(n == 1'b0 && push_cnt == p0 + 1 && last_push == 8'hB1, "R6 accepted after full",
            last_push, 8'hB1);

        // R8: host NACK ends the read
        read_setup(8'h00, nk);
        rbyte(1'b0, d);
        chk(d == 8'h5A, "R8 read before nack", d, 8'h5A);
        n = 1'b1;
        for (int i = 0; i < 9; i++) begin
            tq(); scl_m = 1'b1; tq(); n = n & sda_bus; tq(); scl_m = 1'b0; tq();
        end
        stop_c();
        chk(n == 1'b1, "R8 bus released after nack", n, 1);

        // R9: START in mid byte restarts framing
        start_c();
        bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
        start_c();
        wbyte({TADR, 1'b0}, nk[2]);
        wbyte(8'h07, nk[1]);
        wbyte(8'hE7, nk[0]);
        stop_c();
        chk(nk == 3'b000 && mem[7] == 8'hE7, "R9 restart after partial byte", mem[7], 8'hE7);

        chk(r10_bad == 0, "R10 sda_oe moved while SCL high", r10_bad, 0);
        chk(r11_bad == 0, "R11 reg_wr longer than one cycle", r11_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule